// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Interrupts

This block sits between a host-side register path and a serial audio engine. It holds one queue of 32-bit sample words headed for the line (transmit) and one queue of words arriving from the line (receive). Each queue is 32 words deep. The host writes transmit words and reads receive words. The serializer pops transmit words and pushes receive words.

Each queue reports its fill level on a 6-bit port. A low-water comparison on the transmit level and a high-water comparison on the receive level raise status bits. The thresholds are programmed as the threshold minus one. The serializer can pop an empty transmit queue; this sets a sticky underrun flag, which stays set until a clear pulse arrives. Each queue has a flush request. The flush empties the queue at once, and a busy flag shows the flush for one cycle before it clears itself. A single interrupt line is the OR of the status bits whose enables are set.

Top module: `pcmq_fifo_irq`

## Requirements
- R1: After reset both levels are 0, both flush-busy flags are 0, the underrun flag is 0, the receive high-water status is 0 and the transmit low-water status is 1.
- R2: A host write to a non-full transmit queue raises `tx_level` by one after the next clock edge. `line_tx_data` always shows the oldest stored word, and `line_tx_pop` removes it, so words leave in write order.
- R3: A host write while the transmit queue holds 32 words is dropped. The level stays at 32 and the stored words are unchanged.
- R4: A line push into a non-full receive queue is stored in order. `host_rx_rdata` shows the oldest word and `host_rx_re` removes it. Reading an empty receive queue returns zero and leaves the level at 0. A push into a full receive queue is dropped.
- R5: `st_tx_low` is 1 exactly when `tx_level` is less than or equal to `tx_thr_m1`+1.
- R6: `st_rx_high` is 1 exactly when `rx_level` is greater than or equal to `rx_thr_m1`+1.
- R7: A `line_tx_pop` while the transmit queue is empty returns zero on `line_tx_data` and sets `st_tx_undr` at the next edge. The flag stays set until a cycle with `undr_clr` high and no new underrun. If a new underrun and a clear arrive in the same cycle, the flag stays set.
- R8: A flush request empties its queue at the next edge and raises its busy flag for exactly one cycle. In that cycle, writes or pushes into that queue are dropped. A flush request wins over a same-cycle write, push, read or pop on its queue.
- R9: `irq` is the OR of `st_tx_low & tx_low_ie`, `st_rx_high & rx_high_ie` and `st_tx_undr & tx_undr_ie`.
- R10: A same-cycle write and pop on a transmit queue that is neither empty nor full leaves the level unchanged and keeps the word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_tx_we | input | 1 | Host writes a transmit word |
| host_tx_wdata | input | 32 | Transmit word from host |
| host_rx_re | input | 1 | Host removes the oldest receive word |
| host_rx_rdata | output | 32 | Oldest receive word, zero when empty |
| line_tx_pop | input | 1 | Serializer removes the oldest transmit word |
| line_tx_data | output | 32 | Oldest transmit word, zero when empty |
| line_rx_push | input | 1 | Serializer stores a receive word |
| line_rx_data | input | 32 | Receive word from serializer |
| tx_thr_m1 | input | 5 | Transmit low-water threshold minus one |
| rx_thr_m1 | input | 5 | Receive high-water threshold minus one |
| tx_low_ie | input | 1 | Enable for transmit low-water interrupt |
| rx_high_ie | input | 1 | Enable for receive high-water interrupt |
| tx_undr_ie | input | 1 | Enable for underrun interrupt |
| tx_flush_set | input | 1 | Request a transmit flush |
| rx_flush_set | input | 1 | Request a receive flush |
| undr_clr | input | 1 | Clear the underrun flag |
| tx_flush_busy | output | 1 | Transmit flush in progress |
| rx_flush_busy | output | 1 | Receive flush in progress |
| tx_level | output | 6 | Words in transmit queue |
| rx_level | output | 6 | Words in receive queue |
| st_tx_low | output | 1 | Transmit level at or below threshold |
| st_rx_high | output | 1 | Receive level at or above threshold |
| st_tx_undr | output | 1 | Sticky transmit underrun |
| irq | output | 1 | Interrupt request |

## Verification
The head-of-queue data ports follow the stored state without a clock edge. The bench therefore compares them after it drives a cycle's inputs and before the edge that acts on them. Levels, busy flags and the underrun flag change one edge after their stimulus. The threshold status bits and `irq` follow the level in the same cycle, with no added delay. The bench samples all of these shortly after each rising edge and compares them against a queue model updated for that edge. A flush is observed as level 0 with busy high one edge after the request, and busy low one edge later.

// File: rtl/pcmq_pkg.sv
package pcmq_pkg;
    localparam int unsigned SMP_W      = 32;
    localparam int unsigned FIFO_DEPTH = 32;

    typedef enum logic {
        CMP_AT_OR_BELOW = 1'b0,
        CMP_AT_OR_ABOVE = 1'b1
    } cmp_mode_e;
endpackage

// File: rtl/pcmq_fifo.sv
module pcmq_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_req,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          busy
);
    typedef struct packed {
        logic [AW:0] wptr;
        logic [AW:0] rptr;
        logic        busy;
    } fifo_st_t;

    fifo_st_t     st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic         full;
    logic         wr_ok;
    logic         rd_ok;

    always_comb begin
        st_d  = st_q;
        level = st_q.wptr - st_q.rptr;
        empty = (level == '0);
        full  = (level == LW'(DEPTH));
        head  = empty ? '0 : mem[st_q.rptr[AW-1:0]];
        wr_ok = push && !full && !st_q.busy && !flush_req;
        rd_ok = pop && !empty && !flush_req;
        if (flush_req) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.busy = 1'b1;
        end else begin
            st_d.busy = 1'b0;
            if (wr_ok) st_d.wptr = st_q.wptr + 1'b1;
            if (rd_ok) st_d.rptr = st_q.rptr + 1'b1;
        end
        busy = st_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[st_q.wptr[AW-1:0]] <= push_data;
    end
endmodule

// File: rtl/pcmq_thr_cmp.sv
module pcmq_thr_cmp
    import pcmq_pkg::*;
#(
    parameter int unsigned LW   = 6,
    parameter int unsigned TW   = 5,
    parameter cmp_mode_e   MODE = CMP_AT_OR_BELOW
) (
    input  logic [LW-1:0] level,
    input  logic [TW-1:0] thr_m1,
    output logic          hit
);
    logic [LW-1:0] thr;
    assign thr = LW'(thr_m1) + 1'b1;

    generate
        if (MODE == CMP_AT_OR_BELOW) begin : g_below
            assign hit = (level <= thr);
        end else begin : g_above
            assign hit = (level >= thr);
        end
    endgenerate
endmodule

// File: rtl/pcmq_fifo_irq.sv
module pcmq_fifo_irq
    import pcmq_pkg::*;
#(
    parameter int unsigned SW    = SMP_W,
    parameter int unsigned DEPTH = FIFO_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_tx_we,
    input  logic [SW-1:0]            host_tx_wdata,
    input  logic                     host_rx_re,
    output logic [SW-1:0]            host_rx_rdata,
    input  logic                     line_tx_pop,
    output logic [SW-1:0]            line_tx_data,
    input  logic                     line_rx_push,
    input  logic [SW-1:0]            line_rx_data,
    input  logic [$clog2(DEPTH)-1:0] tx_thr_m1,
    input  logic [$clog2(DEPTH)-1:0] rx_thr_m1,
    input  logic                     tx_low_ie,
    input  logic                     rx_high_ie,
    input  logic                     tx_undr_ie,
    input  logic                     tx_flush_set,
    input  logic                     rx_flush_set,
    input  logic                     undr_clr,
    output logic                     tx_flush_busy,
    output logic                     rx_flush_busy,
    output logic [$clog2(DEPTH):0]   tx_level,
    output logic [$clog2(DEPTH):0]   rx_level,
    output logic                     st_tx_low,
    output logic                     st_rx_high,
    output logic                     st_tx_undr,
    output logic                     irq
);
    localparam int unsigned TW = $clog2(DEPTH);
    localparam int unsigned LW = TW + 1;

    typedef struct packed {
        logic undr;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    tx_empty;
    logic    rx_empty;

    pcmq_fifo #(.W(SW), .DEPTH(DEPTH)) u_tx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (tx_flush_set),
        .push      (host_tx_we),
        .push_data (host_tx_wdata),
        .pop       (line_tx_pop),
        .head      (line_tx_data),
        .level     (tx_level),
        .empty     (tx_empty),
        .busy      (tx_flush_busy)
    );

    pcmq_fifo #(.W(SW), .DEPTH(DEPTH)) u_rx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (rx_flush_set),
        .push      (line_rx_push),
        .push_data (line_rx_data),
        .pop       (host_rx_re),
        .head      (host_rx_rdata),
        .level     (rx_level),
        .empty     (rx_empty),
        .busy      (rx_flush_busy)
    );

    pcmq_thr_cmp #(.LW(LW), .TW(TW), .MODE(CMP_AT_OR_BELOW)) u_tx_cmp (
        .level  (tx_level),
        .thr_m1 (tx_thr_m1),
        .hit    (st_tx_low)
    );

    pcmq_thr_cmp #(.LW(LW), .TW(TW), .MODE(CMP_AT_OR_ABOVE)) u_rx_cmp (
        .level  (rx_level),
        .thr_m1 (rx_thr_m1),
        .hit    (st_rx_high)
    );

    always_comb begin
        st_d = st_q;
        if (line_tx_pop && tx_empty) st_d.undr = 1'b1;
        else if (undr_clr)           st_d.undr = 1'b0;
        st_tx_undr = st_q.undr;
        irq = (st_tx_low & tx_low_ie) | (st_rx_high & rx_high_ie)
            | (st_q.undr & tx_undr_ie);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pcmq_fifo_irq_chk.sv
module pcmq_fifo_irq_chk #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_tx_we,
    input logic          host_rx_re,
    input logic [31:0]   host_rx_rdata,
    input logic          line_tx_pop,
    input logic [31:0]   line_tx_data,
    input logic          tx_flush_set,
    input logic          undr_clr,
    input logic          tx_flush_busy,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic          st_tx_undr
);
    AST_TX_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(DEPTH)); // R3
    AST_FULL_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == LW'(DEPTH) && host_tx_we && !line_tx_pop && !tx_flush_set)
        |=> tx_level == LW'(DEPTH)); // R3
    AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> host_rx_rdata == '0); // R4
    AST_UNDR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tx_pop && tx_level == '0) |=> st_tx_undr); // R7
    AST_UNDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_tx_undr && !undr_clr) |=> st_tx_undr); // R7
    AST_UNDR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == '0) |-> line_tx_data == '0); // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush_set |=> (tx_level == '0 && tx_flush_busy)); // R8
    AST_FLUSH_SELF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush_busy && !tx_flush_set) |=> !tx_flush_busy); // R8
endmodule

bind pcmq_fifo_irq pcmq_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_tx_we    (host_tx_we),
    .host_rx_re    (host_rx_re),
    .host_rx_rdata (host_rx_rdata),
    .line_tx_pop   (line_tx_pop),
    .line_tx_data  (line_tx_data),
    .tx_flush_set  (tx_flush_set),
    .undr_clr      (undr_clr),
    .tx_flush_busy (tx_flush_busy),
    .tx_level      (tx_level),
    .rx_level      (rx_level),
    .st_tx_undr    (st_tx_undr)
);

// File: tb/pcmq_fifo_irq_test.sv
module pcmq_fifo_irq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_tx_we = 0, host_rx_re = 0, line_tx_pop = 0, line_rx_push = 0;
    logic [31:0] host_tx_wdata = 0, line_rx_data = 0;
    logic [31:0] host_rx_rdata, line_tx_data;
    logic [4:0]  tx_thr_m1 = 5'd15, rx_thr_m1 = 5'd15;
    logic        tx_low_ie = 0, rx_high_ie = 0, tx_undr_ie = 0;
    logic        tx_flush_set = 0, rx_flush_set = 0, undr_clr = 0;
    logic        tx_flush_busy, rx_flush_busy;
    logic [5:0]  tx_level, rx_level;
    logic        st_tx_low, st_rx_high, st_tx_undr, irq;

    int unsigned n_cmp = 0, n_bad = 0;
    bit          done = 0;
    logic [31:0] txq[$], rxq[$];
    bit          m_undr = 0, m_txb = 0, m_rxb = 0;

    always #2 clk = ~clk;

    pcmq_fifo_irq uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_low(int sz, logic [4:0] t);
        return sz <= int'(t) + 1;
    endfunction

    function automatic logic exp_high(int sz, logic [4:0] t);
        return sz >= int'(t) + 1;
    endfunction

    task automatic check_state(input string lvl_tag);
        logic el, eh;
        el = exp_low(txq.size(), tx_thr_m1);
        eh = exp_high(rxq.size(), rx_thr_m1);
        chk(lvl_tag, 32'(tx_level), 32'(txq.size()));
        chk("R4 rx level", 32'(rx_level), 32'(rxq.size()));
        chk("R5 tx low", 32'(st_tx_low), 32'(el));
        chk("R6 rx high", 32'(st_rx_high), 32'(eh));
        chk("R7 underrun", 32'(st_tx_undr), 32'(m_undr));
        chk("R8 tx busy", 32'(tx_flush_busy), 32'(m_txb));
        chk("R8 rx busy", 32'(rx_flush_busy), 32'(m_rxb));
        chk("R9 irq", 32'(irq), 32'((el & tx_low_ie) | (eh & rx_high_ie) | (m_undr & tx_undr_ie)));
    endtask

    task automatic step(input logic we, input logic [31:0] wd, input logic re,
                        input logic tp, input logic rp, input logic [31:0] rd,
                        input logic tf, input logic rf, input logic uc);
        int  tsz, rsz;
        bit  both;
        @(negedge clk);
        host_tx_we = we; host_tx_wdata = wd; host_rx_re = re;
        line_tx_pop = tp; line_rx_push = rp; line_rx_data = rd;
        tx_flush_set = tf; rx_flush_set = rf; undr_clr = uc;
        #0;
        tsz = txq.size(); rsz = rxq.size();
        chk("R2 tx head", line_tx_data, tsz > 0 ? txq[0] : 32'h0);
        chk("R4 rx head", host_rx_rdata, rsz > 0 ? rxq[0] : 32'h0);
        both = we && tp && tsz > 0 && tsz < 32 && !tf;
        @(posedge clk);
        #1;
        if (tp && tsz == 0) m_undr = 1;
        else if (uc)        m_undr = 0;
        if (tf) begin
            txq.delete(); m_txb = 1;
        end else begin
            if (we && !m_txb && tsz < 32) txq.push_back(wd);
            if (tp && tsz > 0) void'(txq.pop_front());
            m_txb = 0;
        end
        if (rf) begin
            rxq.delete(); m_rxb = 1;
        end else begin
            if (rp && !m_rxb && rsz < 32) rxq.push_back(rd);
            if (re && rsz > 0) void'(rxq.pop_front());
            m_rxb = 0;
        end
        check_state(both ? "R10 tx level same" : (tsz == 32 ? "R3 tx level full" : "R2 tx level"));
    endtask

    initial begin
        void'($urandom(32'h5eed_0a11));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 tx level", 32'(tx_level), 0);
        chk("R1 rx level", 32'(rx_level), 0);
        chk("R1 tx low", 32'(st_tx_low), 1);
        chk("R1 rx high", 32'(st_rx_high), 0);
        chk("R1 underrun", 32'(st_tx_undr), 0);
        chk("R1 busy", 32'({tx_flush_busy, rx_flush_busy}), 0);
        @(negedge clk);
        rst_n = 1;
        // R3: fill past full on both queues
        for (int i = 0; i < 34; i++)
            step(1, 32'hA000_0000 + i, 0, 0, 1, 32'hB000_0000 + i, 0, 0, 0);
        chk("R3 tx full level", 32'(tx_level), 32);
        chk("R4 rx full level", 32'(rx_level), 32);
        // R8: flush with a write in the busy cycle
        step(0, 0, 0, 0, 0, 0, 1, 1, 0);
        step(1, 32'h1234, 0, 0, 1, 32'h5678, 0, 0, 0);
        chk("R8 write dropped in busy", 32'(tx_level), 0);
        // R7: underrun, set wins over clear, then clear; R4 empty read
        step(0, 0, 1, 1, 0, 0, 0, 0, 0);
        step(0, 0, 1, 1, 0, 0, 0, 0, 1);
        chk("R7 set wins", 32'(st_tx_undr), 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R7 cleared", 32'(st_tx_undr), 0);
        // random phases
        for (int ph = 0; ph < 12; ph++) begin
            int pw, pp;
            pw = (ph % 3 == 0) ? 85 : (ph % 3 == 1) ? 15 : 50;
            pp = 100 - pw;
            tx_thr_m1  = 5'($urandom);
            rx_thr_m1  = 5'($urandom);
            tx_low_ie  = 1'($urandom);
            rx_high_ie = 1'($urandom);
            tx_undr_ie = 1'($urandom);
            for (int i = 0; i < 400; i++)
                step(($urandom % 100) < pw, $urandom, ($urandom % 100) < pp,
                     ($urandom % 100) < pp, ($urandom % 100) < pw, $urandom,
                     ($urandom % 97) == 0, ($urandom % 89) == 0, ($urandom % 16) == 0);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule